// File: doc/BRIEF.md
# Fuse Program and Read Permission Unit

This block sits in front of a one-time-programmable bit array and arbitrates every program and read command aimed at it. A program command names a page, a row and a column and, if allowed, sets exactly that one bit. A read command names a page and a row and returns the whole 32-bit row word. Before acting, the unit decides whether the command is allowed. It checks a global program enable, a sticky range lock, a fixed map from row ranges to lock fuses, and a protected window on page 2. The lock fuses are bits of the same array, so programming one bit can close off a whole range of rows.

Each command runs for a fixed number of cycles. During that time a busy output holds off new commands. At completion the unit raises sticky done and error flags for a downstream interrupt unit. Software clears these flags by writing ones. The fuse storage is modelled as a parameterised register array. It is cleared by reset, except for two anchor bits per page, which reset forces to 1. Analog programming timing is not modelled.

Top module: `fuse_guard`

## Requirements
- R1: A command address is 17 bits: page in [16:13], row in [12:5] and column in [4:0]. An allowed program sets only the addressed bit. A read returns the 32-bit word of the addressed row, where bit n is column n, and ignores the column field.
- R2: While `pgm_enable` is 0, every program command is denied and leaves the array unchanged.
- R3: A one-cycle pulse on `range_lock_req` sets a lock that only reset clears. While the lock is set, programming page 0 rows 44 to 51 is denied. Row 43 and row 52 stay unaffected.
- R4: On page 0 a program command is denied when its row falls in a mapped range and that range's lock fuse (page 0, row, column) is already 1. The map is: row 4 uses (4,31); rows 8–11 use (43,27); rows 12–19 use (43,11); rows 20–27 use (43,13); rows 28–35 use (43,15); row 37 uses (43,28); rows 64–71 use (43,6); rows 72–79 use (43,7); rows 80–87 use (43,8).
- R5: A mapped row whose lock fuse is still 0 can be programmed. A row with no map entry, such as row 43 or row 36, can always be programmed, given R2 and R3.
- R6: On page 2, positions from (row 129, column 0) to (row 255, column 27) inclusive are denied once fuse (page 0, row 43, column 16) is 1. Other page 2 positions and pages 1 and 3 up to PAGES-1 are never row-locked. Programming a page at or above PAGES is denied.
- R7: A read of page 0 rows 12 to 35 returns 0 and flags a read error. Rows 11 and 36 read normally.
- R8: `flags` bit 0 is program-done, bit 1 is program-error, bit 2 is read-done and bit 3 is read-error. Every completed program sets bit 0, and a denied one also sets bit 1. Every completed read sets bit 2.
- R9: A flag bit clears only by writing 1 to the same bit of `flag_clr`, or by reset. A completion in the same cycle as a clear leaves the new flag set.
- R10: After reset `busy`, `flags` and `rd_data` are 0. The range lock is clear. Every array bit is 0 except row 0, columns 1 and 27, of every page, which read as 1.
- R11: A command is accepted when `cmd_valid` is 1 and `busy` is 0. `busy` is then 1 for exactly LATENCY cycles, and `cmd_valid` is ignored during that time.
- R12: A read of a page at or above PAGES returns 0 and flags a read error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pgm_enable | input | 1 | Global permission to program |
| range_lock_req | input | 1 | Pulse that sets the sticky range lock |
| cmd_valid | input | 1 | Command request |
| cmd_read | input | 1 | 1 = read command, 0 = program command |
| cmd_addr | input | 17 | Page, row and column of the command |
| flag_clr | input | 4 | Write-one-to-clear mask for `flags` |
| busy | output | 1 | Command in progress |
| flags | output | 4 | Sticky done and error flags |
| rd_data | output | 32 | Row word from the latest read |

## Verification
Most faults here are silent until a later command exposes them. A lock fuse decoded at the wrong row or column only shows when a program aimed at the protected range finishes without the error flag, LATENCY cycles after it is accepted. The table therefore sets each lock fuse and then probes the rows on both sides of it. A corrupted array bit or a missing anchor shows only on the next read of that row, so every program outcome is confirmed by a read-back. A wrong latency counter changes the width of `busy`, and a lost sticky bit shows as a flag dropping while `flag_clr` is 0.

// File: rtl/fuse_guard_pkg.sv
// Package: shared address layout, flag positions and the page-0 row lock map
// for the fuse permission unit. Assumes a 17-bit command address.
package fuse_guard_pkg;

    localparam int PAGE_W = 4;
    localparam int ROW_W  = 8;
    localparam int COL_W  = 5;
    localparam int WORD_W = 32;
    localparam int ADDR_W = PAGE_W + ROW_W + COL_W;

    // Flag bit positions, decoded by the interrupt unit downstream.
    localparam int FLG_PGM_DONE = 0;
    localparam int FLG_PGM_ERR  = 1;
    localparam int FLG_RD_DONE  = 2;
    localparam int FLG_RD_ERR   = 3;
    localparam int FLG_W        = 4;

    // Anchor bits in row 0 of every page.
    localparam int ANCHOR_COL_A = 1;
    localparam int ANCHOR_COL_B = 27;
    localparam logic [WORD_W-1:0] ANCHOR_WORD =
        (WORD_W'(1) << ANCHOR_COL_A) | (WORD_W'(1) << ANCHOR_COL_B);

    // Row that holds most lock fuses, and the page 2 window lock column.
    localparam logic [ROW_W-1:0] LOCK_ROW      = 8'd43;
    localparam logic [COL_W-1:0] WIN_LOCK_COL  = 5'd16;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } fuse_addr_t;

    typedef struct packed {
        logic              hit;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } lock_ref_t;

    // Map a page-0 row to the fuse that locks it; hit=0 when unmapped.
    function automatic lock_ref_t row_lock_lookup(input logic [ROW_W-1:0] r);
        lock_ref_t ref_v;
        ref_v.hit = 1'b1;
        ref_v.row = LOCK_ROW;
        ref_v.col = '0;
        if (r == 8'd4) begin
            ref_v.row = 8'd4;
            ref_v.col = 5'd31;
        end else if (r >= 8'd8  && r <= 8'd11) ref_v.col = 5'd27;
        else if (r >= 8'd12 && r <= 8'd19) ref_v.col = 5'd11;
        else if (r >= 8'd20 && r <= 8'd27) ref_v.col = 5'd13;
        else if (r >= 8'd28 && r <= 8'd35) ref_v.col = 5'd15;
        else if (r == 8'd37)               ref_v.col = 5'd28;
        else if (r >= 8'd64 && r <= 8'd71) ref_v.col = 5'd6;
        else if (r >= 8'd72 && r <= 8'd79) ref_v.col = 5'd7;
        else if (r >= 8'd80 && r <= 8'd87) ref_v.col = 5'd8;
        else ref_v.hit = 1'b0;
        return ref_v;
    endfunction

endpackage

// File: rtl/fuse_store.sv
// Module: fuse_store
// Register-array model of the fuse bits, one generated bank per page.
// Assumes: bits only ever go 0->1 through wr_en; reset clears the array
// except the anchor bits. Offers one row read port on the command address
// and one single-bit lock read port fixed to page 0.
module fuse_store
    import fuse_guard_pkg::*;
#(
    parameter int PAGES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  fuse_addr_t           addr,
    input  logic                 wr_en,
    input  logic [ROW_W-1:0]     lk_row,
    input  logic [COL_W-1:0]     lk_col,
    output logic [WORD_W-1:0]    rd_word,
    output logic                 lk_bit
);

    localparam int ROWS = 1 << ROW_W;

    logic [WORD_W-1:0] page_words [PAGES];
    logic [WORD_W-1:0] lk_word;

    for (genvar p = 0; p < PAGES; p++) begin : g_page
        logic [WORD_W-1:0] rows_q [ROWS];

        // Purpose: hold the fuse rows of page p; set one bit per allowed program.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int r = 0; r < ROWS; r++) begin
                    rows_q[r] <= (r == 0) ? ANCHOR_WORD : '0;
                end
            end else if (wr_en && (addr.page == PAGE_W'(p))) begin
                rows_q[addr.row][addr.col] <= 1'b1;
            end
        end

        assign page_words[p] = rows_q[addr.row];

        if (p == 0) begin : g_lock_port
            assign lk_word = rows_q[lk_row];
        end

        // Anchors stay set from the end of reset onward.
        assert_anchor_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
            rows_q[0][ANCHOR_COL_A] && rows_q[0][ANCHOR_COL_B]);
    end

    // Purpose: select the addressed page's row; pages past PAGES read as 0.
    always_comb begin
        rd_word = '0;
        for (int p = 0; p < PAGES; p++) begin
            if (addr.page == PAGE_W'(p)) rd_word = page_words[p];
        end
    end

    assign lk_bit = lk_word[lk_col];

endmodule

// File: rtl/fuse_permit.sv
// Module: fuse_permit
// Combinational permission decoder for one command address.
// Assumes: lock fuses live on page 0; lk_bit returns the fuse named by
// lk_row/lk_col in the same cycle.
module fuse_permit
    import fuse_guard_pkg::*;
#(
    parameter int PAGES = 3
) (
    input  fuse_addr_t           addr,
    input  logic                 pgm_en,
    input  logic                 range_lock,
    input  logic                 lk_bit,
    output logic [ROW_W-1:0]     lk_row,
    output logic [COL_W-1:0]     lk_col,
    output logic                 allow,
    output logic                 page_ok,
    output logic                 rd_blocked
);

    localparam logic [ROW_W+COL_W-1:0] WIN_LO = {8'd129, 5'd0};
    localparam logic [ROW_W+COL_W-1:0] WIN_HI = {8'd255, 5'd27};

    logic      need_lock;
    logic      range_hit;
    lock_ref_t map_ref;
    logic [ROW_W+COL_W-1:0] pos;

    assign pos = {addr.row, addr.col};

    // Purpose: pick the lock fuse and the range-lock hit for this address.
    always_comb begin
        lk_row    = '0;
        lk_col    = '0;
        need_lock = 1'b0;
        range_hit = 1'b0;
        map_ref   = row_lock_lookup(addr.row);
        if (addr.page == PAGE_W'(0)) begin
            range_hit = range_lock && (addr.row >= 8'd44) && (addr.row <= 8'd51);
            need_lock = map_ref.hit;
            lk_row    = map_ref.row;
            lk_col    = map_ref.col;
        end else if (addr.page == PAGE_W'(2)) begin
            need_lock = (pos >= WIN_LO) && (pos <= WIN_HI);
            lk_row    = LOCK_ROW;
            lk_col    = WIN_LOCK_COL;
        end
    end

    assign page_ok    = (32'(addr.page) < PAGES);
    assign rd_blocked = (addr.page == PAGE_W'(0)) &&
                        (addr.row >= 8'd12) && (addr.row <= 8'd35);
    assign allow      = pgm_en && page_ok && !range_hit && !(need_lock && lk_bit);

endmodule

// File: rtl/fuse_seq.sv
// Module: fuse_seq
// Command sequencer: accepts one command when idle, holds busy for LATENCY
// cycles, then commits the program or read and updates the sticky flags.
// Assumes: permission inputs are valid for the latched address.
module fuse_seq
    import fuse_guard_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_read,
    input  fuse_addr_t           cmd_addr,
    input  logic                 range_lock_req,
    input  logic [FLG_W-1:0]     flag_clr,
    input  logic                 allow,
    input  logic                 page_ok,
    input  logic                 rd_blocked,
    input  logic [WORD_W-1:0]    store_word,
    output fuse_addr_t           op_addr,
    output logic                 wr_en,
    output logic                 busy,
    output logic                 range_lock,
    output logic [FLG_W-1:0]     flags,
    output logic [WORD_W-1:0]    rd_data
);

    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

    typedef enum logic {ST_IDLE, ST_WAIT} seq_state_t;

    seq_state_t         state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               op_read_q;
    logic               act;
    logic [FLG_W-1:0]   set_vec;

    assign busy  = (state_q == ST_WAIT);
    assign act   = busy && (cnt_q == '0);
    assign wr_en = act && !op_read_q && allow;

    // Purpose: collect this cycle's flag set requests.
    always_comb begin
        set_vec               = '0;
        set_vec[FLG_PGM_DONE] = act && !op_read_q;
        set_vec[FLG_PGM_ERR]  = act && !op_read_q && !allow;
        set_vec[FLG_RD_DONE]  = act && op_read_q;
        set_vec[FLG_RD_ERR]   = act && op_read_q && (rd_blocked || !page_ok);
    end

    // Purpose: idle/wait state, latency count and latched command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            op_read_q <= 1'b0;
            op_addr   <= '0;
        end else if (state_q == ST_IDLE) begin
            if (cmd_valid) begin
                state_q   <= ST_WAIT;
                cnt_q     <= CNT_W'(LATENCY - 1);
                op_read_q <= cmd_read;
                op_addr   <= cmd_addr;
            end
        end else if (act) begin
            state_q <= ST_IDLE;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Purpose: sticky flags; a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) | set_vec;
    end

    // Purpose: sticky range lock, released only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)              range_lock <= 1'b0;
        else if (range_lock_req) range_lock <= 1'b1;
    end

    // Purpose: capture the read result, masked when blocked or off-array.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (act && op_read_q)
            rd_data <= (rd_blocked || !page_ok) ? '0 : store_word;
    end

    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);
    assert_pgm_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLG_PGM_ERR] && !flag_clr[FLG_PGM_ERR]) |=> flags[FLG_PGM_ERR]);
    assert_rd_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLG_RD_ERR] && !flag_clr[FLG_RD_ERR]) |=> flags[FLG_RD_ERR]);
    assert_range_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        range_lock |=> range_lock);
    assert_denied_sets_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q == '0 && !op_read_q && !allow) |=> flags[FLG_PGM_ERR]);
    assert_blocked_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q == '0 && op_read_q && rd_blocked) |=> (rd_data == '0));

endmodule

// File: rtl/fuse_guard.sv
// Module: fuse_guard (top)
// Fuse program/read permission unit: sequencer, permission decoder and
// fuse storage model. Assumes one command in flight at a time.
module fuse_guard
    import fuse_guard_pkg::*;
#(
    parameter int PAGES   = 3,
    parameter int LATENCY = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pgm_enable,
    input  logic                 range_lock_req,
    input  logic                 cmd_valid,
    input  logic                 cmd_read,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [FLG_W-1:0]     flag_clr,
    output logic                 busy,
    output logic [FLG_W-1:0]     flags,
    output logic [WORD_W-1:0]    rd_data
);

    fuse_addr_t          op_addr;
    logic                wr_en;
    logic                range_lock;
    logic                allow;
    logic                page_ok;
    logic                rd_blocked;
    logic                lk_bit;
    logic [ROW_W-1:0]    lk_row;
    logic [COL_W-1:0]    lk_col;
    logic [WORD_W-1:0]   store_word;

    fuse_seq #(.LATENCY(LATENCY)) i_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_read       (cmd_read),
        .cmd_addr       (fuse_addr_t'(cmd_addr)),
        .range_lock_req (range_lock_req),
        .flag_clr       (flag_clr),
        .allow          (allow),
        .page_ok        (page_ok),
        .rd_blocked     (rd_blocked),
        .store_word     (store_word),
        .op_addr        (op_addr),
        .wr_en          (wr_en),
        .busy           (busy),
        .range_lock     (range_lock),
        .flags          (flags),
        .rd_data        (rd_data)
    );

    fuse_permit #(.PAGES(PAGES)) i_permit (
        .addr       (op_addr),
        .pgm_en     (pgm_enable),
        .range_lock (range_lock),
        .lk_bit     (lk_bit),
        .lk_row     (lk_row),
        .lk_col     (lk_col),
        .allow      (allow),
        .page_ok    (page_ok),
        .rd_blocked (rd_blocked)
    );

    fuse_store #(.PAGES(PAGES)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (op_addr),
        .wr_en   (wr_en),
        .lk_row  (lk_row),
        .lk_col  (lk_col),
        .rd_word (store_word),
        .lk_bit  (lk_bit)
    );

    // A write never reaches the array while programming is disabled.
    assert_no_write_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> pgm_enable);

endmodule

// File: tb/test_fuse_guard.sv
module test_fuse_guard;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;
    localparam int NV         = 26;
    localparam int WD_CYCLES  = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pgm_enable = 1'b1;
    logic        range_lock_req = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_read = 1'b0;
    logic [16:0] cmd_addr = '0;
    logic [3:0]  flag_clr = '0;
    logic        busy;
    logic [3:0]  flags;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    fuse_guard #(.PAGES(3), .LATENCY(LAT)) i_fuse_guard (
        .clk(clk), .rst_n(rst_n), .pgm_enable(pgm_enable),
        .range_lock_req(range_lock_req), .cmd_valid(cmd_valid),
        .cmd_read(cmd_read), .cmd_addr(cmd_addr), .flag_clr(flag_clr),
        .busy(busy), .flags(flags), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {read, page, row, col, expect_error, expect_data}
    localparam logic [50:0] VEC [NV] = '{
        {1'b1, 4'd0, 8'd0,   5'd0,  1'b0, 32'h0800_0002}, // R10 anchors
        {1'b0, 4'd0, 8'd5,   5'd3,  1'b0, 32'h0},         // R1
        {1'b1, 4'd0, 8'd5,   5'd17, 1'b0, 32'h0000_0008}, // R1 col ignored
        {1'b0, 4'd0, 8'd4,   5'd0,  1'b0, 32'h0},         // R5
        {1'b0, 4'd0, 8'd4,   5'd31, 1'b0, 32'h0},         // R5 set lock fuse
        {1'b0, 4'd0, 8'd4,   5'd2,  1'b1, 32'h0},         // R4
        {1'b1, 4'd0, 8'd4,   5'd0,  1'b0, 32'h8000_0001}, // R4
        {1'b0, 4'd0, 8'd20,  5'd0,  1'b0, 32'h0},         // R5
        {1'b0, 4'd0, 8'd43,  5'd13, 1'b0, 32'h0},         // R5 unmapped row
        {1'b0, 4'd0, 8'd27,  5'd5,  1'b1, 32'h0},         // R4
        {1'b1, 4'd0, 8'd20,  5'd0,  1'b1, 32'h0},         // R7
        {1'b1, 4'd0, 8'd36,  5'd0,  1'b0, 32'h0},         // R7 boundary
        {1'b0, 4'd0, 8'd36,  5'd0,  1'b0, 32'h0},         // R5
        {1'b1, 4'd0, 8'd11,  5'd0,  1'b0, 32'h0},         // R7 boundary
        {1'b0, 4'd2, 8'd129, 5'd0,  1'b0, 32'h0},         // R6
        {1'b0, 4'd0, 8'd43,  5'd16, 1'b0, 32'h0},         // R6 set window lock
        {1'b0, 4'd2, 8'd129, 5'd1,  1'b1, 32'h0},         // R6
        {1'b0, 4'd2, 8'd255, 5'd27, 1'b1, 32'h0},         // R6 window end
        {1'b0, 4'd2, 8'd255, 5'd28, 1'b0, 32'h0},         // R6 past end
        {1'b0, 4'd2, 8'd128, 5'd31, 1'b0, 32'h0},         // R6 before start
        {1'b1, 4'd2, 8'd255, 5'd0,  1'b0, 32'h1000_0000}, // R6
        {1'b0, 4'd1, 8'd50,  5'd9,  1'b0, 32'h0},         // R6 other page
        {1'b0, 4'd3, 8'd0,   5'd0,  1'b1, 32'h0},         // R6 page off array
        {1'b1, 4'd3, 8'd0,   5'd0,  1'b1, 32'h0},         // R12
        {1'b0, 4'd0, 8'd44,  5'd0,  1'b0, 32'h0},         // R3 lock not set
        {1'b1, 4'd0, 8'd43,  5'd0,  1'b0, 32'h0001_2000}  // R1
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic clear_flags();
        @(negedge clk); flag_clr = 4'hF;
        @(negedge clk); flag_clr = 4'h0;
    endtask

    task automatic run_cmd(input logic rd, input logic [16:0] a,
                           input logic [3:0] clr_hold, output int nbusy);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_read = rd; cmd_addr = a; flag_clr = clr_hold;
        @(negedge clk);
        cmd_valid = 1'b0;
        nbusy = 0;
        while (busy) begin
            nbusy++;
            @(negedge clk);
        end
        flag_clr = 4'h0;
    endtask

    function automatic logic [16:0] fa(input int pg, input int rw, input int cl);
        return {4'(pg), 8'(rw), 5'(cl)};
    endfunction

    task automatic prog(input string req, input logic [16:0] a, input logic err);
        int nb;
        clear_flags();
        run_cmd(1'b0, a, 4'h0, nb);
        check(req, {28'h0, flags}, {28'h0, 2'b00, err, 1'b1});
    endtask

    task automatic rd(input string req, input logic [16:0] a, input logic err,
                      input logic [31:0] exp);
        int nb;
        clear_flags();
        run_cmd(1'b1, a, 4'h0, nb);
        check(req, {28'h0, flags}, {28'h0, err, 1'b1, 2'b00});
        check(req, rd_data, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int nb;
        logic [50:0] v;
        do_reset();

        // R10: reset state
        check("R10 flags", {28'h0, flags}, 32'h0);
        check("R10 busy", {31'h0, busy}, 32'h0);
        check("R10 rd_data", rd_data, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            if (v[50]) rd($sformatf("R1-table read %0d", i), v[49:33], v[32], v[31:0]);
            else       prog($sformatf("R8 table program %0d", i), v[49:33], v[32]);
        end

        // R11: exact busy width; a request during busy is ignored
        clear_flags();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_read = 1'b0; cmd_addr = fa(1, 60, 0);
        @(negedge clk);
        cmd_addr = fa(1, 61, 0);
        nb = 0;
        while (busy) begin
            nb++;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        check("R11 busy cycles", 32'(nb), 32'(LAT));
        rd("R11 accepted", fa(1, 60, 0), 1'b0, 32'h1);
        rd("R11 ignored", fa(1, 61, 0), 1'b0, 32'h0);

        // R2: program enable off
        pgm_enable = 1'b0;
        prog("R2 denied", fa(1, 62, 3), 1'b1);
        pgm_enable = 1'b1;
        rd("R2 unchanged", fa(1, 62, 0), 1'b0, 32'h0);

        // R9: sticky error flag and set-over-clear
        clear_flags();
        run_cmd(1'b0, fa(0, 4, 5), 4'h0, nb);
        run_cmd(1'b0, fa(1, 63, 0), 4'h0, nb);
        check("R9 err kept", {28'h0, flags}, 32'h3);
        @(negedge clk); flag_clr = 4'b0001;
        @(negedge clk); flag_clr = 4'b0000;
        check("R9 partial clear", {28'h0, flags}, 32'h2);
        @(negedge clk); flag_clr = 4'b0010;
        @(negedge clk); flag_clr = 4'b0000;
        check("R9 cleared", {28'h0, flags}, 32'h0);
        run_cmd(1'b0, fa(1, 63, 1), 4'hF, nb);
        check("R9 set wins", {28'h0, flags}, 32'h1);

        // R3: sticky range lock
        @(negedge clk); range_lock_req = 1'b1;
        @(negedge clk); range_lock_req = 1'b0;
        prog("R3 row 45", fa(0, 45, 0), 1'b1);
        prog("R3 row 51", fa(0, 51, 31), 1'b1);
        prog("R3 row 52", fa(0, 52, 0), 1'b0);
        prog("R3 row 43", fa(0, 43, 0), 1'b0);
        rd("R3 row 45 unchanged", fa(0, 45, 0), 1'b0, 32'h0);

        // R10: reset clears array, lock and flags, restores anchors
        do_reset();
        check("R10 flags after reset", {28'h0, flags}, 32'h0);
        check("R10 rd_data after reset", rd_data, 32'h0);
        rd("R10 row 43 cleared", fa(0, 43, 0), 1'b0, 32'h0);
        rd("R10 anchors page 1", fa(1, 0, 0), 1'b0, 32'h0800_0002);
        rd("R10 anchors page 2", fa(2, 0, 0), 1'b0, 32'h0800_0002);
        prog("R10 range lock released", fa(0, 45, 0), 1'b0);
        prog("R10 row 4 lock fuse cleared", fa(0, 4, 2), 1'b0);

        done = 1'b1;
        finish_run();
    end

endmodule